// File: doc/BRIEF.md
# Branch Target Buffer

This block is a direct-mapped table of branch targets. Each entry holds a valid bit, a tag and a target. It sits beside the fetch stage. Each cycle the fetch address goes in, and the block answers in the same cycle whether that address is a remembered taken branch. If it is, the block returns the stored target and offers that target as the next fetch address. Otherwise it offers the sequential address, four bytes on.

Later in the pipeline, a resolve port reports the outcome of each branch. It carries:
- the branch address,
- whether it was a taken branch,
- whether fetch had predicted it,
- the real target.

From these the block keeps the table up to date. A taken branch is written into the table. A predicted branch that falls through is removed. When fetch followed the wrong path, the block raises a one-cycle flush with the address from which fetch must restart. Only taken branches ever occupy an entry.

Top module: `btb_top`

## Requirements
- R1: After reset no fetch address hits.
- R2: A lookup hits, in the same cycle, only when the entry at index PC[IDX_W+1:2] is valid and its tag equals PC[PC_W-1:IDX_W+2]. PC[1:0] are ignored. A hit returns the stored target.
- R3: The offered next fetch address is the stored target on a hit and the lookup address plus 4 on a miss.
- R4: A resolve reporting a taken branch writes its tag and actual target into its entry. The lookup sees the new entry from the next cycle on.
- R5: A resolve reporting a predicted branch that was not taken invalidates its entry only when the stored tag matches. An entry at the same index with a different tag is left in place.
- R6: A predicted branch that resolves not taken raises flush in the following cycle, with restart address equal to the branch address plus 4.
- R7: A predicted branch that resolves taken, whose entry holds the same target, raises no flush.
- R8: A taken branch that was not predicted, or whose entry is missing or holds a different target, raises flush in the following cycle with restart address equal to the actual target.
- R9: A resolve that is neither predicted nor taken leaves the table unchanged and raises no flush.
- R10: A lookup in the same cycle as a resolve to the same entry sees the contents from before that resolve.
- R11: Flush stays low in any cycle not preceded by a resolve that calls for one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Fetch address being looked up |
| lk_hit | output | 1 | Lookup found a valid matching entry |
| lk_target | output | PC_W | Stored target of the hit entry |
| fetch_next_pc | output | PC_W | Target on a hit, lk_pc+4 on a miss |
| rs_valid | input | 1 | A branch outcome is presented this cycle |
| rs_pc | input | PC_W | Address of the resolved instruction |
| rs_taken | input | 1 | Instruction was a taken branch |
| rs_predicted | input | 1 | Fetch had a hit for this instruction |
| rs_target | input | PC_W | Actual branch target |
| flush | output | 1 | Kill wrong-path instructions and restart fetch |
| restart_pc | output | PC_W | Address fetch restarts from when flush is high |

## Verification
The bench builds the block with 8 entries and 32-bit addresses. With only three index bits, addresses 32 bytes apart share an entry, so tag mismatches are easy to reach. Those cases cover deleting with a foreign tag in place, a predicted hit whose entry was replaced, and a target change on an existing entry. A randomized phase over a few dozen aliasing addresses mixes every combination of taken and predicted against a model table that the bench derives from the requirements.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // Instructions are word aligned; these low bits never take part in indexing.
  localparam int unsigned BTB_OFS  = 2;
  localparam int unsigned BTB_STEP = 4;

  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_WRITE = 2'd1,
    UPD_CLEAR = 2'd2
  } btb_upd_e;
endpackage

// File: rtl/btb_field_split.sv
module btb_field_split
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6,
  localparam int TAG_W = PC_W - IDX_W - int'(BTB_OFS)
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  logic unused_ofs;

  assign idx        = pc[IDX_W+BTB_OFS-1:BTB_OFS];
  assign tag        = pc[PC_W-1:IDX_W+BTB_OFS];
  assign unused_ofs = ^pc[BTB_OFS-1:0];
endmodule

// File: rtl/btb_array.sv
module btb_array
  import btb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int PC_W    = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = PC_W - IDX_W - int'(BTB_OFS)
) (
  input  logic             clk,
  input  logic             rst_n,
  // fetch-side read
  input  logic [IDX_W-1:0] rda_idx,
  output logic             rda_valid,
  output logic [TAG_W-1:0] rda_tag,
  output logic [PC_W-1:0]  rda_tgt,
  // resolve-side read
  input  logic [IDX_W-1:0] rdb_idx,
  output logic             rdb_valid,
  output logic [TAG_W-1:0] rdb_tag,
  output logic [PC_W-1:0]  rdb_tgt,
  // single update port
  input  btb_upd_e         upd,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_tgt
);
  logic [ENTRIES-1:0] vld_vec;
  logic [TAG_W-1:0]   tag_arr [ENTRIES];
  logic [PC_W-1:0]    tgt_arr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic             sel;
    logic             wr_en;
    logic             vld_d;
    logic             vld_q;
    logic [TAG_W-1:0] tag_q;
    logic [PC_W-1:0]  tgt_q;

    assign sel   = (wr_idx == IDX_W'(g));
    assign wr_en = sel && (upd == UPD_WRITE);

    always_comb begin
      vld_d = vld_q;
      if (wr_en) begin
        vld_d = 1'b1;
      end else if (sel && (upd == UPD_CLEAR)) begin
        vld_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
      end else begin
        vld_q <= vld_d;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en) begin
        tag_q <= wr_tag;
        tgt_q <= wr_tgt;
      end
    end

    assign vld_vec[g] = vld_q;
    assign tag_arr[g] = tag_q;
    assign tgt_arr[g] = tgt_q;
  end

  assign rda_valid = vld_vec[rda_idx];
  assign rda_tag   = tag_arr[rda_idx];
  assign rda_tgt   = tgt_arr[rda_idx];
  assign rdb_valid = vld_vec[rdb_idx];
  assign rdb_tag   = tag_arr[rdb_idx];
  assign rdb_tgt   = tgt_arr[rdb_idx];
endmodule

// File: rtl/btb_resolve_ctl.sv
module btb_resolve_ctl
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int TAG_W = 24
) (
  input  logic             rs_valid,
  input  logic             rs_taken,
  input  logic             rs_predicted,
  input  logic [PC_W-1:0]  rs_pc,
  input  logic [PC_W-1:0]  rs_target,
  input  logic [TAG_W-1:0] rs_tag,
  input  logic             ent_valid,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [PC_W-1:0]  ent_tgt,
  output btb_upd_e         upd,
  output logic             flush_d,
  output logic [PC_W-1:0]  restart_d
);
  logic ent_match;
  logic tgt_agree;

  assign ent_match = ent_valid && (ent_tag == rs_tag);
  assign tgt_agree = ent_match && (ent_tgt == rs_target);

  always_comb begin
    upd       = UPD_NONE;
    flush_d   = 1'b0;
    restart_d = rs_target;
    if (rs_valid) begin
      if (rs_taken) begin
        upd     = UPD_WRITE;
        flush_d = !(rs_predicted && tgt_agree);
      end else if (rs_predicted) begin
        flush_d   = 1'b1;
        restart_d = rs_pc + PC_W'(BTB_STEP);
        if (ent_match) begin
          upd = UPD_CLEAR;
        end
      end
    end
  end
endmodule

// File: rtl/btb_top.sv
module btb_top
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic [PC_W-1:0] lk_target,
  output logic [PC_W-1:0] fetch_next_pc,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken,
  input  logic            rs_predicted,
  input  logic [PC_W-1:0] rs_target,
  output logic            flush,
  output logic [PC_W-1:0] restart_pc
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W - int'(BTB_OFS);

  logic [IDX_W-1:0] lk_idx, rs_idx;
  logic [TAG_W-1:0] lk_tag, rs_tag;
  logic             a_valid, b_valid;
  logic [TAG_W-1:0] a_tag, b_tag;
  logic [PC_W-1:0]  a_tgt, b_tgt;
  btb_upd_e         upd;
  logic             flush_d;
  logic [PC_W-1:0]  restart_d;
  logic             flush_q;
  logic [PC_W-1:0]  restart_q;

  btb_field_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split_lk (
    .pc(lk_pc), .idx(lk_idx), .tag(lk_tag)
  );

  btb_field_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split_rs (
    .pc(rs_pc), .idx(rs_idx), .tag(rs_tag)
  );

  btb_array #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .rda_idx   (lk_idx),
    .rda_valid (a_valid),
    .rda_tag   (a_tag),
    .rda_tgt   (a_tgt),
    .rdb_idx   (rs_idx),
    .rdb_valid (b_valid),
    .rdb_tag   (b_tag),
    .rdb_tgt   (b_tgt),
    .upd       (upd),
    .wr_idx    (rs_idx),
    .wr_tag    (rs_tag),
    .wr_tgt    (rs_target)
  );

  btb_resolve_ctl #(.PC_W(PC_W), .TAG_W(TAG_W)) u_ctl (
    .rs_valid     (rs_valid),
    .rs_taken     (rs_taken),
    .rs_predicted (rs_predicted),
    .rs_pc        (rs_pc),
    .rs_target    (rs_target),
    .rs_tag       (rs_tag),
    .ent_valid    (b_valid),
    .ent_tag      (b_tag),
    .ent_tgt      (b_tgt),
    .upd          (upd),
    .flush_d      (flush_d),
    .restart_d    (restart_d)
  );

  // Fetch side: same-cycle answer from the current table contents.
  assign lk_hit        = a_valid && (a_tag == lk_tag);
  assign lk_target     = a_tgt;
  assign fetch_next_pc = lk_hit ? a_tgt : (lk_pc + PC_W'(BTB_STEP));

  // Resolve side: one registered stage for flush and restart address.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_q <= 1'b0;
    end else begin
      flush_q <= flush_d;
    end
  end

  always_ff @(posedge clk) begin
    if (flush_d) begin
      restart_q <= restart_d;
    end
  end

  assign flush      = flush_q;
  assign restart_pc = restart_q;
endmodule

// File: rtl/btb_top_chk.sv
module btb_top_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] lk_pc,
  input logic            lk_hit,
  input logic [PC_W-1:0] lk_target,
  input logic            rs_valid,
  input logic [PC_W-1:0] rs_pc,
  input logic            rs_taken,
  input logic            rs_predicted,
  input logic [PC_W-1:0] rs_target,
  input logic            flush,
  input logic [PC_W-1:0] restart_pc
);
  p_insert_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_taken) |=>
      ((lk_pc != $past(rs_pc)) || (lk_hit && (lk_target == $past(rs_target)))));

  p_delete_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_predicted && !rs_taken) |=>
      ((lk_pc != $past(rs_pc)) || !lk_hit));

  p_fallthrough_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_predicted && !rs_taken) |=>
      (flush && (restart_pc == $past(rs_pc) + PC_W'(4))));

  p_unpredicted_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_taken && !rs_predicted) |=>
      (flush && (restart_pc == $past(rs_target))));

  p_quiet_resolve_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_taken && !rs_predicted) |=> !flush);

  p_table_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rs_valid || (!rs_taken && !rs_predicted)) |=>
      (!$stable(lk_pc) || ($stable(lk_hit) && (!lk_hit || $stable(lk_target)))));

  p_idle_no_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |=> !flush);
endmodule

bind btb_top btb_top_chk #(.PC_W(PC_W)) u_btb_top_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lk_pc        (lk_pc),
  .lk_hit       (lk_hit),
  .lk_target    (lk_target),
  .rs_valid     (rs_valid),
  .rs_pc        (rs_pc),
  .rs_taken     (rs_taken),
  .rs_predicted (rs_predicted),
  .rs_target    (rs_target),
  .flush        (flush),
  .restart_pc   (restart_pc)
);

// File: tb/btb_top_bench.sv
`timescale 1ns/1ps
module btb_top_bench;
  localparam int PW = 32;
  localparam int NE = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [PW-1:0] lk_pc;
  logic          lk_hit;
  logic [PW-1:0] lk_target;
  logic [PW-1:0] fetch_next_pc;
  logic          rs_valid;
  logic [PW-1:0] rs_pc;
  logic          rs_taken;
  logic          rs_predicted;
  logic [PW-1:0] rs_target;
  logic          flush;
  logic [PW-1:0] restart_pc;

  always #2.5 clk = ~clk;

  btb_top #(.PC_W(PW), .ENTRIES(NE)) u_btb_top (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit),
    .lk_target(lk_target), .fetch_next_pc(fetch_next_pc),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
    .rs_predicted(rs_predicted), .rs_target(rs_target),
    .flush(flush), .restart_pc(restart_pc)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic          fl;
    logic [PW-1:0] rpc;
    string         req;
  } exp_t;
  exp_t sb_q[$];

  // Model table built from the requirements.
  logic          m_vld [NE];
  logic [PW-1:0] m_pc  [NE];
  logic [PW-1:0] m_tgt [NE];

  function automatic int ix(logic [PW-1:0] pc);
    return int'(pc[IW+1:2]);
  endfunction

  function automatic logic m_hit(logic [PW-1:0] pc);
    return m_vld[ix(pc)] && (m_pc[ix(pc)][PW-1:IW+2] == pc[PW-1:IW+2]);
  endfunction

  task automatic chk(string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_look(string req, logic [PW-1:0] pc);
    logic h;
    h = m_hit(pc);
    chk({req, " hit"}, PW'(lk_hit), PW'(h));
    if (h) chk({req, " target"}, lk_target, m_tgt[ix(pc)]);
    chk({req, " R3 next"}, fetch_next_pc, h ? m_tgt[ix(pc)] : pc + 32'd4);
  endtask

  task automatic look(string req, logic [PW-1:0] pc);
    @(negedge clk);
    lk_pc = pc;
    #1;
    check_look(req, pc);
  endtask

  // Driver: presents a resolve, optionally with a same-cycle lookup,
  // and pushes the expected flush outcome into the scoreboard.
  task automatic resolve(string req, logic [PW-1:0] pc, logic tk, logic pr,
                         logic [PW-1:0] tgt, bit also_look, logic [PW-1:0] lpc);
    exp_t e;
    logic h;
    int   i;
    @(negedge clk);
    rs_valid = 1'b1; rs_pc = pc; rs_taken = tk;
    rs_predicted = pr; rs_target = tgt;
    if (also_look) begin
      lk_pc = lpc;
      #1;
      check_look("R10 same-cycle", lpc);
    end
    i = ix(pc);
    h = m_hit(pc);
    e.req = req;
    e.rpc = tgt;
    e.fl  = 1'b0;
    if (tk) begin
      e.fl = !(pr && h && (m_tgt[i] == tgt));
    end else if (pr) begin
      e.fl  = 1'b1;
      e.rpc = pc + 32'd4;
    end
    @(posedge clk);
    sb_q.push_back(e);
    if (tk) begin
      m_vld[i] = 1'b1; m_pc[i] = pc; m_tgt[i] = tgt;
    end else if (pr && h) begin
      m_vld[i] = 1'b0;
    end
    @(negedge clk);
    rs_valid = 1'b0;
  endtask

  // Monitor: compares flush and restart address one cycle after each resolve.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk({e.req, " flush"}, PW'(flush), PW'(e.fl));
        if (e.fl) chk({e.req, " restart"}, restart_pc, e.rpc);
      end else begin
        chk("R11 idle flush", PW'(flush), '0);
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NE; i++) begin
      m_vld[i] = 1'b0; m_pc[i] = '0; m_tgt[i] = '0;
    end
    rst_n = 1'b0; rs_valid = 1'b0; rs_pc = '0; rs_taken = 1'b0;
    rs_predicted = 1'b0; rs_target = '0; lk_pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset, sequential next address on a miss (R3).
    look("R1 reset", 32'h0000_0100);
    look("R1 reset", 32'h0000_011C);

    // R8 + R4: unpredicted taken inserts and flushes to the target.
    resolve("R8 unpredicted taken", 32'h100, 1'b1, 1'b0, 32'h400, 1'b0, '0);
    look("R4 R2 after insert", 32'h100);
    look("R2 low bits ignored", 32'h103);
    look("R2 alias tag miss", 32'h120);

    // R7: predicted, same target: no flush.
    resolve("R7 predicted same target", 32'h100, 1'b1, 1'b1, 32'h400, 1'b0, '0);
    // R8: predicted, different target: flush to new target and update (R4).
    resolve("R8 target changed", 32'h100, 1'b1, 1'b1, 32'h500, 1'b0, '0);
    look("R4 updated target", 32'h100);

    // R5/R6: predicted not-taken with a foreign tag keeps the resident entry.
    resolve("R6 foreign tag fallthrough", 32'h120, 1'b0, 1'b1, 32'h0, 1'b0, '0);
    look("R5 foreign entry kept", 32'h100);
    // R5/R6: matching tag deletes.
    resolve("R6 fallthrough", 32'h100, 1'b0, 1'b1, 32'h0, 1'b0, '0);
    look("R5 entry deleted", 32'h100);

    // R9: neither predicted nor taken leaves an entry in place.
    resolve("R8 insert 200", 32'h200, 1'b1, 1'b0, 32'h900, 1'b0, '0);
    resolve("R9 quiet resolve", 32'h200, 1'b0, 1'b0, 32'h0, 1'b0, '0);
    look("R9 table unchanged", 32'h200);

    // R10: lookup in the resolve cycle sees the old entry.
    resolve("R8 insert 300", 32'h300, 1'b1, 1'b0, 32'h600, 1'b0, '0);
    resolve("R6 delete 300", 32'h300, 1'b0, 1'b1, 32'h0, 1'b1, 32'h300);
    look("R10 gone next cycle", 32'h300);
    resolve("R4 reinsert 300", 32'h300, 1'b1, 1'b0, 32'h640, 1'b1, 32'h300);
    look("R10 new entry next cycle", 32'h300);

    // Randomized mix over aliasing addresses.
    for (int k = 0; k < 400; k++) begin
      logic [PW-1:0] p, t;
      logic tk, pr;
      p  = 32'h1000 + (($urandom % 24) * 4);
      t  = 32'h8000 + (($urandom % 4) * 4);
      tk = 1'($urandom % 2);
      pr = ($urandom % 4 == 0) ? 1'($urandom % 2) : m_hit(p);
      if (k % 3 == 0) look("R2 random lookup", 32'h1000 + (($urandom % 24) * 4));
      resolve("R4-R9 random", p, tk, pr, t, (k % 5 == 0), p);
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule